// File: doc/BRIEF.md
# Event Counter Bank With Snapshot Read

This block counts events in two groups of four 16-bit counters. The outside group watches event lines that arrive from outside the clock domain. Each of those lines is brought into the domain by a two-stage synchronizer. A rising-edge detector follows, so each low-to-high transition adds one to its counter no matter how long the line stays high. Once an outside counter reaches 65535 it holds there.

The core group counts rising edges on event strobes that the surrounding core already produces in the clock domain, for example a pulse at the start of each received command and a pulse when a message completes without error. These counters roll over from 65535 to 0.

Each group has one read request and one clear request. A read request copies all four live counts into a snapshot register in a single cycle, so the four values belong to the same instant. A clear request zeroes all four counters of that group. When a clear and an event fall in the same cycle, the clear wins.

Top module: `evcnt_top`

## Requirements
- R1: Each outside counter increases by one for each rising edge on its event line. The new value appears in the counter on the third rising clock edge after the line goes high. A line that stays high for many cycles counts once.
- R2: Each core counter increases by one on the first clock edge at which its strobe is sampled high after having been low. A strobe held high counts once.
- R3: An outside counter at 65535 stays at 65535 when further edges arrive.
- R4: A core counter at 65535 goes to 0 on the next counted edge.
- R5: A read request sampled at a clock edge drives the group's snapshot-valid output high for exactly the following cycle. At that edge the snapshot register takes the four counts the counters held when the request was sampled, with channel i in bits [16*i+15 : 16*i].
- R6: Between read requests, the snapshot output of a group does not change, even while events are being counted.
- R7: A clear request sampled at a clock edge sets all four counters of its group to zero and leaves the other group untouched. A read in the same cycle captures the values from before the clear.
- R8: When a clear request and a counted edge fall on the same clock edge, the counter ends at zero.
- R9: After reset, all counters, both snapshot registers and both valid outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_evt | input | 4 | Asynchronous outside event lines, one per channel |
| core_evt | input | 4 | In-domain core event strobes, one per channel |
| ext_rd | input | 1 | Snapshot request for the outside group |
| ext_clr | input | 1 | Clear request for the outside group |
| core_rd | input | 1 | Snapshot request for the core group |
| core_clr | input | 1 | Clear request for the core group |
| ext_snap | output | 64 | Outside group snapshot, four 16-bit fields |
| ext_snap_vld | output | 1 | Outside snapshot updated in the previous cycle |
| core_snap | output | 64 | Core group snapshot, four 16-bit fields |
| core_snap_vld | output | 1 | Core snapshot updated in the previous cycle |

## Verification
The hardest cases to reach are the two counter limits. Each one needs 65,535 or more counted edges. The stimulus toggles all eight event inputs together every other cycle, so both groups climb side by side. It reads both groups at 65534 and 65535 and again two edges later, which shows one group holding at the limit and the other rolling over to 1. Clear-beats-event also needs exact timing on the outside group: the clear is raised two clock edges after the line goes high, so that it lands on the same edge as the edge pulse coming out of the synchronizer.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

    localparam int EVC_CNT_W    = 16;
    localparam int EVC_CHANNELS = 4;
    localparam int EVC_SYNC_LEN = 2;

    // Behaviour at the top of the count range
    typedef enum logic {
        LIMIT_HOLD = 1'b0,
        LIMIT_ROLL = 1'b1
    } limit_mode_e;

    // Requests that act on one group as a whole
    typedef struct packed {
        logic rd;
        logic clr;
    } grp_req_t;

endpackage

// File: rtl/evcnt_edge.sv
module evcnt_edge #(
    parameter int N_CH   = evcnt_pkg::EVC_CHANNELS,
    parameter int STAGES = evcnt_pkg::EVC_SYNC_LEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] evt_in,
    output logic [N_CH-1:0] rise
);

    logic [N_CH-1:0] lvl;
    logic [N_CH-1:0] lvl_q;

    generate
        if (STAGES > 0) begin : g_sync
            logic [N_CH-1:0] chain [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int s = 0; s < STAGES; s++) chain[s] <= '0;
                end else begin
                    chain[0] <= evt_in;
                    for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
                end
            end
            assign lvl = chain[STAGES-1];
        end else begin : g_direct
            assign lvl = evt_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/evcnt_cell.sv
module evcnt_cell
    import evcnt_pkg::*;
#(
    parameter int          CNT_W = EVC_CNT_W,
    parameter limit_mode_e MODE  = LIMIT_HOLD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic at_top;
    logic step;

    assign at_top = (cnt == TOP);
    assign step   = inc && !(MODE == LIMIT_HOLD && at_top);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int          N_CH  = EVC_CHANNELS,
    parameter int          CNT_W = EVC_CNT_W,
    parameter limit_mode_e MODE  = LIMIT_HOLD,
    localparam int         BUS_W = N_CH * CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CH-1:0]  hit,
    input  grp_req_t         req,
    output logic [BUS_W-1:0] live,
    output logic [BUS_W-1:0] snap,
    output logic             snap_vld
);

    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_ch
            evcnt_cell #(
                .CNT_W (CNT_W),
                .MODE  (MODE)
            ) u_cell (
                .clk (clk),
                .rst (rst),
                .clr (req.clr),
                .inc (hit[ch]),
                .cnt (live[ch*CNT_W +: CNT_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            snap     <= '0;
            snap_vld <= 1'b0;
        end else begin
            snap_vld <= req.rd;
            if (req.rd) snap <= live;
        end
    end

endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
    import evcnt_pkg::*;
#(
    parameter int N_CH   = EVC_CHANNELS,
    parameter int CNT_W  = EVC_CNT_W,
    parameter int STAGES = EVC_SYNC_LEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_CH-1:0]       ext_evt,
    input  logic [N_CH-1:0]       core_evt,
    input  logic                  ext_rd,
    input  logic                  ext_clr,
    input  logic                  core_rd,
    input  logic                  core_clr,
    output logic [N_CH*CNT_W-1:0] ext_snap,
    output logic                  ext_snap_vld,
    output logic [N_CH*CNT_W-1:0] core_snap,
    output logic                  core_snap_vld
);

    localparam int BUS_W = N_CH * CNT_W;

    logic [N_CH-1:0]  ext_hit;
    logic [N_CH-1:0]  core_hit;
    logic [BUS_W-1:0] ext_live;
    logic [BUS_W-1:0] core_live;
    grp_req_t         ext_req;
    grp_req_t         core_req;

    assign ext_req  = '{rd: ext_rd,  clr: ext_clr};
    assign core_req = '{rd: core_rd, clr: core_clr};

    evcnt_edge #(.N_CH(N_CH), .STAGES(STAGES)) u_ext_edge (
        .clk (clk), .rst (rst), .evt_in (ext_evt), .rise (ext_hit)
    );

    evcnt_edge #(.N_CH(N_CH), .STAGES(0)) u_core_edge (
        .clk (clk), .rst (rst), .evt_in (core_evt), .rise (core_hit)
    );

    evcnt_bank #(.N_CH(N_CH), .CNT_W(CNT_W), .MODE(LIMIT_HOLD)) u_ext_bank (
        .clk (clk), .rst (rst), .hit (ext_hit), .req (ext_req),
        .live (ext_live), .snap (ext_snap), .snap_vld (ext_snap_vld)
    );

    evcnt_bank #(.N_CH(N_CH), .CNT_W(CNT_W), .MODE(LIMIT_ROLL)) u_core_bank (
        .clk (clk), .rst (rst), .hit (core_hit), .req (core_req),
        .live (core_live), .snap (core_snap), .snap_vld (core_snap_vld)
    );

endmodule

// File: rtl/evcnt_checker.sv
module evcnt_checker #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ext_rd,
    input logic                  ext_clr,
    input logic                  core_rd,
    input logic                  core_clr,
    input logic [N_CH*CNT_W-1:0] ext_live,
    input logic [N_CH*CNT_W-1:0] core_live,
    input logic [N_CH*CNT_W-1:0] ext_snap,
    input logic [N_CH*CNT_W-1:0] core_snap,
    input logic                  ext_snap_vld,
    input logic                  core_snap_vld
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R5
    ext_vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ext_snap_vld == $past(ext_rd));

    // R5
    core_snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        core_rd |=> core_snap == $past(core_live));

    // R6
    ext_snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_rd |=> $stable(ext_snap));

    // R6
    core_snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !core_rd |=> $stable(core_snap));

    // R7
    ext_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ext_clr |=> ext_live == '0);

    // R7
    core_clear_chk: assert property (@(posedge clk) disable iff (rst)
        core_clr |=> core_live == '0);

    genvar ch;
    generate
        for (ch = 0; ch < N_CH; ch++) begin : g_ch
            // R3
            ext_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (ext_live[ch*CNT_W +: CNT_W] == TOP && !ext_clr)
                |=> ext_live[ch*CNT_W +: CNT_W] == TOP);

            // R1
            ext_step_chk: assert property (@(posedge clk) disable iff (rst)
                !ext_clr |=> (ext_live[ch*CNT_W +: CNT_W] == $past(ext_live[ch*CNT_W +: CNT_W]))
                          || (ext_live[ch*CNT_W +: CNT_W] == $past(ext_live[ch*CNT_W +: CNT_W]) + CNT_W'(1)));

            // R4
            core_step_chk: assert property (@(posedge clk) disable iff (rst)
                !core_clr |=> (core_live[ch*CNT_W +: CNT_W] == $past(core_live[ch*CNT_W +: CNT_W]))
                           || (core_live[ch*CNT_W +: CNT_W] == CNT_W'($past(core_live[ch*CNT_W +: CNT_W]) + CNT_W'(1))));
        end
    endgenerate

endmodule

bind evcnt_top evcnt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_evcnt_checker (
    .clk           (clk),
    .rst           (rst),
    .ext_rd        (ext_rd),
    .ext_clr       (ext_clr),
    .core_rd       (core_rd),
    .core_clr      (core_clr),
    .ext_live      (ext_live),
    .core_live     (core_live),
    .ext_snap      (ext_snap),
    .core_snap     (core_snap),
    .ext_snap_vld  (ext_snap_vld),
    .core_snap_vld (core_snap_vld)
);

// File: tb/evcnt_top_bench.sv
module evcnt_top_bench;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int MX = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] ext_evt = '0;
    logic [N-1:0] core_evt = '0;
    logic ext_rd = 1'b0, ext_clr = 1'b0, core_rd = 1'b0, core_clr = 1'b0;
    logic [N*W-1:0] ext_snap, core_snap;
    logic ext_snap_vld, core_snap_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int exp_ext [N];
    int exp_core [N];

    always #4 clk = ~clk;

    evcnt_top u_evcnt_top (
        .clk (clk), .rst (rst),
        .ext_evt (ext_evt), .core_evt (core_evt),
        .ext_rd (ext_rd), .ext_clr (ext_clr),
        .core_rd (core_rd), .core_clr (core_clr),
        .ext_snap (ext_snap), .ext_snap_vld (ext_snap_vld),
        .core_snap (core_snap), .core_snap_vld (core_snap_vld)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Pulse the selected lines of both groups n times, two cycles per edge
    task automatic pulse(input logic [N-1:0] emask, input logic [N-1:0] cmask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ext_evt = emask; core_evt = cmask;
            @(negedge clk); ext_evt = '0;    core_evt = '0;
        end
        for (int i = 0; i < N; i++) begin
            if (emask[i]) exp_ext[i]  = (exp_ext[i] + n > MX) ? MX : exp_ext[i] + n;
            if (cmask[i]) exp_core[i] = (exp_core[i] + n) % (MX + 1);
        end
    endtask

    task automatic read_ext(input string req);
        @(negedge clk); ext_rd = 1'b1;
        @(negedge clk); ext_rd = 1'b0;
        check({req, " ext valid"}, ext_snap_vld, 1);
        for (int i = 0; i < N; i++) check({req, " ext count"}, ext_snap[i*W +: W], exp_ext[i]);
    endtask

    task automatic read_core(input string req);
        @(negedge clk); core_rd = 1'b1;
        @(negedge clk); core_rd = 1'b0;
        check({req, " core valid"}, core_snap_vld, 1);
        for (int i = 0; i < N; i++) check({req, " core count"}, core_snap[i*W +: W], exp_core[i]);
    endtask

    task automatic t_reset();
        check("R9 ext snap", ext_snap, 0);
        check("R9 core snap", core_snap, 0);
        check("R9 ext vld", ext_snap_vld, 0);
        check("R9 core vld", core_snap_vld, 0);
        read_ext("R9");
        read_core("R9");
    endtask

    task automatic t_edges();
        pulse(4'b1001, 4'b0000, 3);
        pulse(4'b1000, 4'b0000, 2);
        // channel 1 held high for many cycles counts once (R1)
        @(negedge clk); ext_evt = 4'b0010;
        repeat (12) @(negedge clk);
        ext_evt = '0;
        exp_ext[1] = exp_ext[1] + 1;
        settle();
        read_ext("R1");
        // a single edge shows up on the third clock edge
        @(negedge clk); ext_evt = 4'b0100; ext_rd = 1'b1;
        @(negedge clk); @(negedge clk);
        ext_rd = 1'b0;
        @(negedge clk); ext_rd = 1'b1;
        @(negedge clk); ext_rd = 1'b0;
        check("R1 third-edge latency", ext_snap[2*W +: W], exp_ext[2] + 1);
        ext_evt = '0;
        exp_ext[2] = exp_ext[2] + 1;
    endtask

    task automatic t_core();
        pulse(4'b0000, 4'b0011, 4);
        pulse(4'b0000, 4'b0100, 1);
        // strobe held high counts once (R2)
        @(negedge clk); core_evt = 4'b1000;
        repeat (6) @(negedge clk);
        core_evt = '0;
        exp_core[3] = exp_core[3] + 1;
        read_core("R2");
    endtask

    task automatic t_hold();
        logic [N*W-1:0] e0, c0;
        e0 = ext_snap; c0 = core_snap;
        pulse(4'b1111, 4'b1111, 3);
        settle();
        check("R6 ext snap held", ext_snap, e0);
        check("R6 core snap held", core_snap, c0);
        check("R5 ext vld low", ext_snap_vld, 0);
        read_ext("R5");
        read_core("R5");
    endtask

    task automatic t_rd_clr();
        @(negedge clk); ext_rd = 1'b1; ext_clr = 1'b1;
        @(negedge clk); ext_rd = 1'b0; ext_clr = 1'b0;
        for (int i = 0; i < N; i++) check("R7 pre-clear snap", ext_snap[i*W +: W], exp_ext[i]);
        for (int i = 0; i < N; i++) exp_ext[i] = 0;
        read_ext("R7 cleared");
        read_core("R7 other group kept");
        @(negedge clk); core_clr = 1'b1;
        @(negedge clk); core_clr = 1'b0;
        for (int i = 0; i < N; i++) exp_core[i] = 0;
        read_core("R7 core cleared");
    endtask

    task automatic t_clear_wins();
        pulse(4'b0001, 4'b0000, 2);
        settle();
        // outside edge pulse reaches its counter on the third clock edge
        @(negedge clk); ext_evt = 4'b0001;
        @(negedge clk);
        @(negedge clk); ext_clr = 1'b1;
        @(negedge clk); ext_clr = 1'b0;
        ext_evt = '0;
        for (int i = 0; i < N; i++) exp_ext[i] = 0;
        settle();
        read_ext("R8 ext");
        pulse(4'b0000, 4'b0010, 2);
        @(negedge clk); core_evt = 4'b0010; core_clr = 1'b1;
        @(negedge clk); core_evt = '0;      core_clr = 1'b0;
        for (int i = 0; i < N; i++) exp_core[i] = 0;
        read_core("R8 core");
    endtask

    task automatic t_limits();
        for (int i = 0; i < N; i++) begin exp_ext[i] = 0; exp_core[i] = 0; end
        @(negedge clk); ext_clr = 1'b1; core_clr = 1'b1;
        @(negedge clk); ext_clr = 1'b0; core_clr = 1'b0;
        pulse(4'b1111, 4'b1111, MX - 1);
        settle();
        read_ext("R3 below top");
        read_core("R4 below top");
        pulse(4'b1111, 4'b1111, 1);
        settle();
        read_ext("R3 at top");
        read_core("R4 at top");
        pulse(4'b1111, 4'b1111, 2);
        settle();
        read_ext("R3 saturated");
        read_core("R4 wrapped");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin exp_ext[i] = 0; exp_core[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_edges();
        t_core();
        t_hold();
        t_rd_clr();
        t_clear_wins();
        t_limits();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule